// File: doc/BRIEF.md
# Low-Voltage Reset Supervisor

This block is the digital half of a supply supervisor. An analog comparator pair outside the block reports two facts about the supply: whether it sits at or below the falling trip level, and whether it has climbed above the higher rising trip level. The block synchronizes both signals and exposes the low-supply condition as a live status flag. It filters that condition over consecutive clock cycles and, when the condition persists, raises a system reset together with an active-low reset pin for external devices.

Once raised, the reset is held until the supply is seen above the rising level. The gap between the two trip levels therefore gives hysteresis. Configuration inputs select whether the supply is watched at all, whether a detected low supply may cause a reset, and whether watching continues while the core is in stop mode. A sticky cause bit records that a low-voltage reset happened. Software clears it with a write-one-to-clear strobe.

Top module: `lvr_supervisor`

## Requirements
- R1: In reset (rst_n low, sampled at a clock edge) all state clears. After reset, sys_reset is 0, ext_rst_n is 1, cause_flag is 0 and low_flag is 0. Watching starts on the first clock after reset, with no warm-up period.
- R2: The monitor is active when cfg_mon_en is 1 and either core_in_stop is 0 or cfg_stop_en is 1. While it is inactive, low_flag reads 0, the consecutive count is cleared, no reset is raised, and a reset being held is released on the next clock edge.
- R3: While the monitor is active, low_flag equals sup_low_raw delayed by the two-flop synchronizer: it reads 1 from the second clock edge after sup_low_raw rises. No further filtering is applied.
- R4: A reset is raised only after the synchronized low input has been 1 on 9 consecutive clock edges. Raw low held across N sampling edges gives sys_reset high after edge N+2 when N >= 9, and never when N <= 8. Any single edge with the input at 0 restarts the count.
- R5: With cfg_rst_en at 0, no reset is raised. The consecutive count saturates at 9 and does not wrap. If cfg_rst_en is then set while the supply is still low, the reset is raised on the very next clock edge.
- R6: While a reset is held, sup_low_raw activity and changes to cfg_rst_en have no effect on sys_reset.
- R7: A held reset is released on the clock edge after the synchronized sup_high_raw reads 1, or when the monitor becomes inactive (see R2). Dropping sup_low_raw alone does not release it (hysteresis).
- R8: ext_rst_n is the inverse of sys_reset in every cycle.
- R9: cause_flag is set on the edge where a reset is raised and stays set after release. A one-cycle cause_clr pulse clears it, but a set on the same edge wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sup_low_raw | input | 1 | Comparator: supply at or below the falling trip level |
| sup_high_raw | input | 1 | Comparator: supply above the rising trip level |
| cfg_mon_en | input | 1 | Enable supply watching |
| cfg_rst_en | input | 1 | Allow a low supply to raise reset |
| cfg_stop_en | input | 1 | Keep watching while the core is stopped |
| core_in_stop | input | 1 | Core is in stop mode |
| cause_clr | input | 1 | Write-one-to-clear strobe for cause_flag |
| low_flag | output | 1 | Synchronized low-supply status |
| sys_reset | output | 1 | Active-high system reset request |
| ext_rst_n | output | 1 | Active-low external reset pin drive |
| cause_flag | output | 1 | Sticky low-voltage reset cause |

## Verification
The main sweep holds the low input for every run length from 0 to 12 edges. It repeats this under all sixteen combinations of monitor enable, reset enable, stop enable and stop mode. This separates the 8- and 9-edge lengths at the filter boundary, and it separates the gating terms from one another. Directed patterns cover the remaining behaviour. One breaks a long low run with a single high edge, to prove the count restarts. One holds the supply low past saturation before reset is enabled. One toggles the low input and the reset enable during a hold. One releases the hold through monitor shutdown instead of through the rising input.

// File: rtl/lvr_pkg.sv
// Package: shared types for the low-voltage reset supervisor.
// Assumes: nothing beyond a single clock domain for all consumers.
package lvr_pkg;

    // Hold controller state: watching the supply, or holding reset.
    typedef enum logic {
        ST_WATCH = 1'b0,
        ST_HOLD  = 1'b1
    } hold_state_e;

    // Smallest counter width that can hold values 0..limit.
    function automatic int unsigned count_width(input int unsigned limit);
        return (limit < 2) ? 1 : $clog2(limit + 1);
    endfunction

endpackage

// File: rtl/lvr_sync.sv
// Module: lvr_sync
// Multi-stage flop synchronizer for a vector of asynchronous level inputs.
// Assumes: each bit is a slow level, so per-bit synchronization is enough;
// STAGES >= 2; all stages clear on synchronous active-low reset.
module lvr_sync #(
    parameter int unsigned WIDTH  = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);

    logic [WIDTH-1:0] stage_q [STAGES];

    // First stage: capture the asynchronous input.
    always_ff @(posedge clk) begin
        if (!rst_n) stage_q[0] <= '0;
        else        stage_q[0] <= d_async;
    end

    genvar gi;
    generate
        for (gi = 1; gi < STAGES; gi++) begin : g_stage
            // Later stage: shift the previous stage forward.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[gi] <= '0;
                else        stage_q[gi] <= stage_q[gi-1];
            end
        end
    endgenerate

    assign q_sync = stage_q[STAGES-1];

endmodule

// File: rtl/lvr_low_filter.sv
// Module: lvr_low_filter
// Counts consecutive edges on which the synchronized low-supply input is set.
// The counter saturates at FILTER_LEN and clears on any clear edge or when
// disabled. trip_now flags the edge that completes (or extends past) the
// FILTER_LEN-th consecutive low edge.
// Assumes: low_s is already synchronized; FILTER_LEN >= 1.
module lvr_low_filter #(
    parameter int unsigned FILTER_LEN = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic low_s,
    output logic trip_now
);
    import lvr_pkg::*;

    localparam int unsigned CNT_W = count_width(FILTER_LEN);
    localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(FILTER_LEN);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FILTER_LEN - 1);

    logic [CNT_W-1:0] run_cnt;
    logic             counting;

    assign counting = enable && low_s;
    assign trip_now = counting && (run_cnt >= CNT_LAST);

    // Saturating run counter of consecutive low edges.
    always_ff @(posedge clk) begin
        if (!rst_n)                run_cnt <= '0;
        else if (!counting)        run_cnt <= '0;
        else if (run_cnt != CNT_MAX) run_cnt <= run_cnt + 1'b1;
    end

    // R5
    cnt_saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_cnt <= CNT_MAX);

    // R4
    cnt_needs_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_cnt != '0) |-> $past(counting));

    // R4
    cnt_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !counting |=> (run_cnt == '0));

endmodule

// File: rtl/lvr_hold_ctrl.sv
// Module: lvr_hold_ctrl
// Two-state controller that raises and holds the low-voltage reset and keeps
// the sticky cause bit. Enters hold on a filtered trip when reset is enabled,
// leaves it only on the synchronized rising-level input or monitor shutdown.
// Assumes: trip_now and rise_s are synchronous to clk.
module lvr_hold_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic mon_act,
    input  logic rst_en,
    input  logic trip_now,
    input  logic rise_s,
    input  logic cause_clr,
    output logic holding,
    output logic cause_q
);
    import lvr_pkg::*;

    hold_state_e state_q, state_d;
    logic        enter_hold;

    assign enter_hold = (state_q == ST_WATCH) && mon_act && rst_en && trip_now;

    // Next-state selection for watch / hold.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_WATCH: if (enter_hold)          state_d = ST_HOLD;
            ST_HOLD:  if (rise_s || !mon_act)  state_d = ST_WATCH;
            default:                           state_d = ST_WATCH;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_WATCH;
        else        state_q <= state_d;
    end

    // Sticky cause bit: set on hold entry, write-one-to-clear, set wins.
    always_ff @(posedge clk) begin
        if (!rst_n)          cause_q <= 1'b0;
        else if (enter_hold) cause_q <= 1'b1;
        else if (cause_clr)  cause_q <= 1'b0;
    end

    assign holding = (state_q == ST_HOLD);

    // R6
    hold_sticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (holding && !rise_s && mon_act) |=> holding);

    // R2
    mon_off_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mon_act |=> !holding);

    // R5
    no_rst_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!holding && !rst_en) |=> !holding);

    // R9
    cause_on_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(holding) |-> cause_q);

endmodule

// File: rtl/lvr_supervisor.sv
// Module: lvr_supervisor (top)
// Low-voltage reset supervisor: synchronizes the two comparator levels,
// gates monitoring by enable and stop-mode settings, filters the low level
// over FILTER_LEN consecutive edges, and holds reset until the rising level.
// Assumes: comparator inputs are asynchronous levels; configuration inputs
// are synchronous and quasi-static.
module lvr_supervisor #(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned FILTER_LEN  = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sup_low_raw,
    input  logic sup_high_raw,
    input  logic cfg_mon_en,
    input  logic cfg_rst_en,
    input  logic cfg_stop_en,
    input  logic core_in_stop,
    input  logic cause_clr,
    output logic low_flag,
    output logic sys_reset,
    output logic ext_rst_n,
    output logic cause_flag
);

    localparam int unsigned CMP_W = 2;

    logic [CMP_W-1:0] cmp_raw, cmp_sync;
    logic             low_s, rise_s;
    logic             mon_act;
    logic             trip_now;
    logic             holding;

    assign cmp_raw = {sup_high_raw, sup_low_raw};
    assign low_s   = cmp_sync[0];
    assign rise_s  = cmp_sync[1];

    // Monitor runs when enabled, and in stop mode only if stop watching is on.
    assign mon_act = cfg_mon_en && (!core_in_stop || cfg_stop_en);

    lvr_sync #(
        .WIDTH  (CMP_W),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (cmp_raw),
        .q_sync  (cmp_sync)
    );

    lvr_low_filter #(
        .FILTER_LEN (FILTER_LEN)
    ) u_filter (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (mon_act && !holding),
        .low_s    (low_s),
        .trip_now (trip_now)
    );

    lvr_hold_ctrl u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .mon_act   (mon_act),
        .rst_en    (cfg_rst_en),
        .trip_now  (trip_now),
        .rise_s    (rise_s),
        .cause_clr (cause_clr),
        .holding   (holding),
        .cause_q   (cause_flag)
    );

    assign low_flag  = low_s && mon_act;
    assign sys_reset = holding;
    assign ext_rst_n = !holding;

    // R4
    reset_after_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sys_reset) |-> $past(low_s));

    // R7
    release_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sys_reset) |-> ($past(rise_s) || !$past(mon_act)));

endmodule

// File: tb/lvr_supervisor_bench.sv
module lvr_supervisor_bench;

    localparam int CLK_PERIOD = 10;
    localparam int FILT       = 9;

    logic clk = 1'b0;
    logic rst_n;
    logic sup_low_raw, sup_high_raw;
    logic cfg_mon_en, cfg_rst_en, cfg_stop_en, core_in_stop, cause_clr;
    logic low_flag, sys_reset, ext_rst_n, cause_flag;

    int n_checks = 0;
    int n_fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lvr_supervisor #(.SYNC_STAGES(2), .FILTER_LEN(FILT)) u_lvr_supervisor (
        .clk          (clk),
        .rst_n        (rst_n),
        .sup_low_raw  (sup_low_raw),
        .sup_high_raw (sup_high_raw),
        .cfg_mon_en   (cfg_mon_en),
        .cfg_rst_en   (cfg_rst_en),
        .cfg_stop_en  (cfg_stop_en),
        .core_in_stop (core_in_stop),
        .cause_clr    (cause_clr),
        .low_flag     (low_flag),
        .sys_reset    (sys_reset),
        .ext_rst_n    (ext_rst_n),
        .cause_flag   (cause_flag)
    );

    task automatic check(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Raise reset via a long low run with everything enabled.
    task automatic trip_full();
        cfg_mon_en = 1; cfg_rst_en = 1; cfg_stop_en = 0; core_in_stop = 0;
        sup_low_raw = 1; tick(FILT + 2);
        sup_low_raw = 0; tick(1);
    endtask

    task automatic release_and_clear();
        sup_low_raw = 0; sup_high_raw = 1; tick(4);
        sup_high_raw = 0;
        cause_clr = 1; tick(1); cause_clr = 0; tick(1);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_checks++; n_fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        rst_n = 0; sup_low_raw = 0; sup_high_raw = 0;
        cfg_mon_en = 1; cfg_rst_en = 1; cfg_stop_en = 0; core_in_stop = 0;
        cause_clr = 0;
        tick(3);
        // R1: reset state
        check("R1 sys_reset", sys_reset, 1'b0);
        check("R1 ext_rst_n", ext_rst_n, 1'b1);
        check("R1 cause_flag", cause_flag, 1'b0);
        check("R1 low_flag", low_flag, 1'b0);
        rst_n = 1;
        tick(2);

        // Sweep: run length x all four configuration bits.
        for (int cfg = 0; cfg < 16; cfg++) begin
            for (int n = 0; n <= 12; n++) begin
                logic act, exp;
                cfg_mon_en   = cfg[0];
                cfg_rst_en   = cfg[1];
                cfg_stop_en  = cfg[2];
                core_in_stop = cfg[3];
                sup_low_raw = 0; sup_high_raw = 0;
                act = cfg[0] && (!cfg[3] || cfg[2]);
                exp = act && cfg[1] && (n >= FILT);
                tick(3);
                for (int j = 0; j < n; j++) begin
                    sup_low_raw = 1;
                    tick(1);
                    // R3: flag after two edges, gated by monitor (R2, R10 path)
                    check("R3 low_flag", low_flag, act && (j >= 1));
                    // R4: reset after N+2 edges
                    check("R4 sys_reset run", sys_reset,
                          act && cfg[1] && (j >= FILT + 1));
                end
                sup_low_raw = 0;
                tick(3);
                // R4 / R2 / R5: final reset decision; R7 hysteresis holds it
                check("R4 sys_reset", sys_reset, exp);
                check("R8 ext_rst_n", ext_rst_n, !exp);
                check("R9 cause set", cause_flag, exp);
                if (exp) begin
                    // R6: falling activity and rst_en changes ignored
                    sup_low_raw = 1; tick(2);
                    cfg_rst_en = 0; sup_low_raw = 0; tick(2);
                    check("R6 hold", sys_reset, 1'b1);
                    cfg_rst_en = cfg[1];
                end
                sup_high_raw = 1;
                tick(4);
                check("R7 release", sys_reset, 1'b0);
                check("R8 ext_rst_n release", ext_rst_n, 1'b1);
                check("R9 sticky", cause_flag, exp);
                sup_high_raw = 0;
                cause_clr = 1; tick(1); cause_clr = 0;
                check("R9 cleared", cause_flag, 1'b0);
            end
        end

        // R4: one high edge in the middle restarts the count.
        cfg_mon_en = 1; cfg_rst_en = 1; cfg_stop_en = 0; core_in_stop = 0;
        sup_low_raw = 1; tick(7);
        sup_low_raw = 0; tick(1);
        sup_low_raw = 1; tick(7);
        sup_low_raw = 0; tick(3);
        check("R4 restart", sys_reset, 1'b0);

        // R5: saturate with rst_en off, then enable: reset on next edge.
        cfg_rst_en = 0;
        sup_low_raw = 1; tick(40);
        check("R5 no reset", sys_reset, 1'b0);
        cfg_rst_en = 1; tick(1);
        check("R5 saturate trip", sys_reset, 1'b1);
        check("R9 cause on trip", cause_flag, 1'b1);
        release_and_clear();
        check("R7 released", sys_reset, 1'b0);

        // R2: monitor shutdown releases a held reset on the next edge.
        trip_full();
        check("R2 pre hold", sys_reset, 1'b1);
        cfg_mon_en = 0; tick(1);
        check("R2 mon off release", sys_reset, 1'b0);
        check("R2 flag off", low_flag, 1'b0);
        cfg_mon_en = 1;
        release_and_clear();

        // R2: entering stop without stop-watch releases hold.
        trip_full();
        core_in_stop = 1; tick(1);
        check("R2 stop release", sys_reset, 1'b0);
        core_in_stop = 0;
        release_and_clear();

        // R9: clear and set on the same edge, set wins.
        cfg_mon_en = 1; cfg_rst_en = 1;
        sup_low_raw = 1; tick(FILT + 1);
        cause_clr = 1; tick(1); cause_clr = 0;
        check("R9 set wins", cause_flag, 1'b1);
        check("R4 trip edge", sys_reset, 1'b1);
        release_and_clear();
        check("R9 final clear", cause_flag, 1'b0);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule